// File: doc/BRIEF.md
# Excluded-Tag Random Tag Generator

This block produces a 4-bit allocation tag for memory-tagging hardware. Each request advances a 16-bit Fibonacci LFSR four steps to get a 4-bit hop count. It then walks forward from a start tag through the 16 possible tag values and skips every value that the exclusion mask forbids. The result is the chosen tag and a refreshed state word that packs the new tag with the advanced seed. The caller writes that word back so that the next request continues the pseudo-random sequence.

A second mode takes the start tag and the hop count directly from the caller, with no use of the LFSR. This mode serves tag-offset arithmetic on pointers. The walk takes one value per clock. The caller issues a single-cycle request while the block is idle and waits for the done pulse. Requests that arrive while the block is busy are dropped.

Top module: `tag_pick_unit`

## Requirements
- R1: In random mode (`add_mode_i`=0), the excluded set is `op_mask_i | ctrl_i[15:0]`. Bit k set means that tag value k is never returned, unless R2 applies.
- R2: When the active exclusion mask is 16'hFFFF, the returned tag is 0.
- R3: A random request performs four LFSR steps. Each step computes f = s[5]^s[3]^s[2]^s[0] and then sets s = {f, s[15:1]}. The f of step i (i = 0..3) becomes hop-count bit i.
- R4: With a hop count of zero, the result is the start tag if that value is allowed. Otherwise the result is the first allowed value above it, counting modulo 16.
- R5: With a hop count of N > 0, the block repeats N times: move up by one modulo 16, then keep moving up while the value is excluded. The walk wraps from 15 to 0.
- R6: `state_i` and `state_o` carry the start tag or result tag in bits [3:0] and the seed in bits [23:8]. After a random request, `state_o` holds the result tag, the advanced seed and zero in bits [7:4].
- R7: If the seed field is zero and `ctrl_i[16]` is 1, the seed 16'h0001 is used in its place. If the seed is zero and `ctrl_i[16]` is 0, the seed stays zero and the hop count is zero.
- R8: In add mode (`add_mode_i`=1), the start tag is `add_start_i`, the hop count is `add_off_i` and the mask is `ctrl_i[15:0]` only. `op_mask_i` is ignored, and `state_o` keeps its previous value.
- R9: An accepted request (`req_i`=1 while `busy_o`=0) raises `busy_o` from the next cycle. `done_o` pulses for one cycle, in the same cycle that `busy_o` falls. A request completes within 260 cycles.
- R10: A `req_i` asserted while `busy_o`=1 is ignored. `tag_o` and `state_o` change only in a cycle where `done_o` is 1.
- R11: After synchronous active-low reset, `tag_o`, `state_o`, `busy_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| add_mode_i | input | 1 | 1 selects explicit hop count, 0 selects LFSR |
| op_mask_i | input | 16 | Per-request exclusion mask (random mode only) |
| ctrl_i | input | 17 | [15:0] base exclusion mask, [16] random-seed enable |
| state_i | input | 24 | Start tag [3:0], seed [23:8] |
| add_start_i | input | 4 | Start tag in add mode |
| add_off_i | input | 4 | Hop count in add mode |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tag_o | output | 4 | Selected tag |
| state_o | output | 24 | Updated state word |

## Verification
A corrupted remaining-hop counter or a corrupted current value in the walk gives a wrong `tag_o` at the next done pulse. It can also push completion past the latency bound. A wrong LFSR tap or a wrong bit order shows up as a wrong seed field in `state_o` at the very first random request. When a chained run feeds `state_o` back, the error also spreads into every later tag. A capture that leaks while busy changes the result of the request already in flight, and it shows at that request's done pulse.

// File: rtl/tagpick_pkg.sv
// Package: shared constants for the tag generator.
// Assumes the seed field position is fixed by the state-word layout.
package tagpick_pkg;
    localparam int SEED_LSB = 8;    // seed field starts at bit 8 of the state word
endpackage

// File: rtl/tag_lfsr.sv
// Module: tag_lfsr
// Advances a Fibonacci LFSR STEPS times in one combinational pass.
// Each step's feedback bit becomes one bit of the hop count, LSB first.
// Assumes TAP_MASK selects the feedback taps and the feedback enters at the MSB.
module tag_lfsr #(
    parameter int          SEED_W   = 16,
    parameter int          STEPS    = 4,
    parameter logic [15:0] TAP_MASK = 16'h002D
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [STEPS-1:0]  offs_o
);
    logic [SEED_W-1:0] chain [0:STEPS];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic fb;
        // feedback is the parity of the tapped bits
        assign fb           = ^(chain[g] & TAP_MASK[SEED_W-1:0]);
        assign chain[g + 1] = {fb, chain[g][SEED_W-1:1]};
        assign offs_o[g]    = fb;
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/tag_seed_guard.sv
// Module: tag_seed_guard
// Replaces an all-zero seed with a fixed nonzero value when random mode is on.
// Assumes FALLBACK is nonzero.
module tag_seed_guard #(
    parameter int                SEED_W   = 16,
    parameter logic [SEED_W-1:0] FALLBACK = 1
) (
    input  logic [SEED_W-1:0] seed_i,
    input  logic              rnd_i,
    output logic [SEED_W-1:0] seed_o
);
    // substitute only when the seed is stuck at zero and random mode is on
    always_comb begin
        seed_o = seed_i;
        if (rnd_i && (seed_i == '0)) seed_o = FALLBACK;
    end
endmodule

// File: rtl/tag_walker.sv
// Module: tag_walker
// Walks the tag values one per clock: hops offs_i allowed values upward from
// start_i, or settles on the first allowed value when offs_i is zero.
// An all-excluded mask yields zero. fin_o and res_o are combinational and
// valid in the last active cycle. Assumes load_i only while busy_o is low.
module tag_walker #(
    parameter int TAG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [TAG_W-1:0]        start_i,
    input  logic [TAG_W-1:0]        offs_i,
    input  logic [(1<<TAG_W)-1:0]   mask_i,
    output logic                    busy_o,
    output logic                    fin_o,
    output logic [TAG_W-1:0]        res_o,
    output logic [TAG_W-1:0]        tag_o
);
    localparam int NTAG = 1 << TAG_W;

    logic             active_q;
    logic [TAG_W-1:0] cur_q;
    logic [TAG_W-1:0] remain_q;
    logic [NTAG-1:0]  mask_q;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] cur_nx;
    logic             all_ex;

    // next candidate and finish decision
    always_comb begin
        cur_nx = cur_q + 1'b1;
        all_ex = &mask_q;
        fin_o  = active_q && (all_ex || ((remain_q == '0) && !mask_q[cur_q]));
        res_o  = all_ex ? '0 : cur_q;
    end

    // walk state: capture on load, step once per cycle, settle on finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            remain_q <= '0;
            mask_q   <= '0;
            tag_q    <= '0;
        end else if (!active_q) begin
            if (load_i) begin
                active_q <= 1'b1;
                cur_q    <= start_i;
                remain_q <= offs_i;
                mask_q   <= mask_i;
            end
        end else if (fin_o) begin
            active_q <= 1'b0;
            tag_q    <= res_o;
        end else begin
            cur_q <= cur_nx;
            if ((remain_q != '0) && !mask_q[cur_nx]) remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = active_q;
    assign tag_o  = tag_q;
endmodule

// File: rtl/tag_pick_unit.sv
// Module: tag_pick_unit (top)
// Excluded-tag generator. In random mode it derives the hop count from the
// LFSR seed in state_i and rewrites state_o. In add mode it uses the
// caller's start and hop count and leaves state_o alone.
// Assumes a single-cycle req_i; requests while busy are dropped.
module tag_pick_unit #(
    parameter int              TAG_W    = 4,
    parameter int              SEED_W   = 16,
    parameter logic [15:0]     TAP_MASK = 16'h002D,
    parameter logic [SEED_W-1:0] FALLBACK_SEED = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_i,
    input  logic                                  add_mode_i,
    input  logic [(1<<TAG_W)-1:0]                 op_mask_i,
    input  logic [(1<<TAG_W):0]                   ctrl_i,
    input  logic [tagpick_pkg::SEED_LSB+SEED_W-1:0] state_i,
    input  logic [TAG_W-1:0]                      add_start_i,
    input  logic [TAG_W-1:0]                      add_off_i,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic [TAG_W-1:0]                      tag_o,
    output logic [tagpick_pkg::SEED_LSB+SEED_W-1:0] state_o
);
    import tagpick_pkg::*;

    localparam int NTAG    = 1 << TAG_W;
    localparam int STATE_W = SEED_LSB + SEED_W;

    logic [SEED_W-1:0]  seed_in;
    logic [SEED_W-1:0]  seed_safe;
    logic [SEED_W-1:0]  seed_adv;
    logic [TAG_W-1:0]   lfsr_offs;
    logic [TAG_W-1:0]   walk_start;
    logic [TAG_W-1:0]   walk_offs;
    logic [NTAG-1:0]    walk_mask;
    logic               walk_busy;
    logic               walk_fin;
    logic [TAG_W-1:0]   walk_res;
    logic               load;
    logic               mode_q;
    logic [SEED_W-1:0]  seed_q;
    logic               done_q;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_nx;

    assign seed_in = state_i[SEED_LSB +: SEED_W];

    tag_seed_guard #(.SEED_W(SEED_W), .FALLBACK(FALLBACK_SEED)) i_guard (
        .seed_i (seed_in),
        .rnd_i  (ctrl_i[NTAG]),
        .seed_o (seed_safe)
    );

    tag_lfsr #(.SEED_W(SEED_W), .STEPS(TAG_W), .TAP_MASK(TAP_MASK)) i_lfsr (
        .seed_i (seed_safe),
        .seed_o (seed_adv),
        .offs_o (lfsr_offs)
    );

    // operand selection for the two modes
    always_comb begin
        if (add_mode_i) begin
            walk_start = add_start_i;
            walk_offs  = add_off_i;
            walk_mask  = ctrl_i[NTAG-1:0];
        end else begin
            walk_start = state_i[TAG_W-1:0];
            walk_offs  = lfsr_offs;
            walk_mask  = op_mask_i | ctrl_i[NTAG-1:0];
        end
    end

    assign load = req_i && !walk_busy;

    tag_walker #(.TAG_W(TAG_W)) i_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .start_i (walk_start),
        .offs_i  (walk_offs),
        .mask_i  (walk_mask),
        .busy_o  (walk_busy),
        .fin_o   (walk_fin),
        .res_o   (walk_res),
        .tag_o   (tag_o)
    );

    // assemble the refreshed state word
    always_comb begin
        state_nx                       = '0;
        state_nx[SEED_LSB +: SEED_W]   = seed_q;
        state_nx[TAG_W-1:0]            = walk_res;
    end

    // request context, done pulse and state word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            seed_q  <= '0;
            done_q  <= 1'b0;
            state_q <= '0;
        end else begin
            done_q <= walk_fin;
            if (load) begin
                mode_q <= add_mode_i;
                seed_q <= seed_adv;
            end
            if (walk_fin && !mode_q) state_q <= state_nx;
        end
    end

    assign busy_o  = walk_busy;
    assign done_o  = done_q;
    assign state_o = state_q;
endmodule

// File: rtl/tag_pick_chk.sv
// Module: tag_pick_chk
// Protocol and timing checks for tag_pick_unit, attached by bind.
// Assumes the default 4-bit tag and 24-bit state widths.
module tag_pick_chk #(
    parameter int LAT_LIMIT = 260
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [3:0]  tag_o,
    input logic [23:0] state_o
);
    logic [9:0] lat_cnt;

    // count cycles spent busy
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) lat_cnt <= '0;
        else                   lat_cnt <= lat_cnt + 1'b1;
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy_o && $past(busy_o)));

    // R9
    lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt <= LAT_LIMIT);

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> ($stable(state_o) || done_o));

    // R10
    hold_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> ($stable(tag_o) || done_o));

    // R6
    state_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[7:4] == 4'h0);
endmodule

bind tag_pick_unit tag_pick_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .tag_o   (tag_o),
    .state_o (state_o)
);

// File: tb/test_tag_pick_unit.sv
module test_tag_pick_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        add_mode_i = 1'b0;
    logic [15:0] op_mask_i = '0;
    logic [16:0] ctrl_i = '0;
    logic [23:0] state_i = '0;
    logic [3:0]  add_start_i = '0;
    logic [3:0]  add_off_i = '0;
    logic        busy_o, done_o;
    logic [3:0]  tag_o;
    logic [23:0] state_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [3:0]  exp_tag = '0;
    logic [23:0] exp_state = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_pick_unit i_tag_pick_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .add_mode_i(add_mode_i),
        .op_mask_i(op_mask_i), .ctrl_i(ctrl_i), .state_i(state_i),
        .add_start_i(add_start_i), .add_off_i(add_off_i),
        .busy_o(busy_o), .done_o(done_o), .tag_o(tag_o), .state_o(state_o)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // behavioural reference: returns tag and state word for one request
    task automatic model(input bit addm, input logic [15:0] opm, input logic [16:0] ctl,
                         input logic [23:0] st, input logic [3:0] ast, input logic [3:0] aoff,
                         input logic [23:0] prev_state,
                         output logic [3:0] rtag, output logic [23:0] rstate);
        int seed, off, t, top, mask;
        if (addm) begin
            mask = ctl[15:0]; off = aoff; t = ast; seed = 0;
        end else begin
            mask = opm | ctl[15:0];
            seed = st[23:8];
            if (seed == 0 && ctl[16]) seed = 1;
            off = 0;
            for (int i = 0; i < 4; i++) begin
                top = ((seed >> 5) ^ (seed >> 3) ^ (seed >> 2) ^ seed) & 1;
                seed = (top << 15) | (seed >> 1);
                off |= top << i;
            end
            t = st[3:0];
        end
        if (mask == 16'hFFFF) t = 0;
        else if (off == 0) begin
            while ((mask >> t) & 1) t = (t + 1) % 16;
        end else begin
            while (off > 0) begin
                t = (t + 1) % 16;
                while ((mask >> t) & 1) t = (t + 1) % 16;
                off--;
            end
        end
        rtag = t[3:0];
        rstate = addm ? prev_state : {seed[15:0], 4'h0, t[3:0]};
    endtask

    // compare held outputs on an idle or busy cycle
    task automatic cmp_hold(input string rq);
        check(tag_o == exp_tag, rq, tag_o, exp_tag);
        check(state_o == exp_state, rq, state_o, exp_state);
    endtask

    // issue one request and compare on every clock until done
    task automatic run_req(input string rq, input bit addm, input logic [15:0] opm,
                           input logic [16:0] ctl, input logic [23:0] st,
                           input logic [3:0] ast, input logic [3:0] aoff,
                           input bit inject);
        logic [3:0] nt; logic [23:0] ns; bit seen;
        model(addm, opm, ctl, st, ast, aoff, exp_state, nt, ns);
        add_mode_i = addm; op_mask_i = opm; ctrl_i = ctl; state_i = st;
        add_start_i = ast; add_off_i = aoff; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after request", busy_o, 1);
        if (inject) begin
            // R10: a second request while busy with different operands
            add_mode_i = ~addm; op_mask_i = ~opm; ctrl_i = 17'h0FFFF; state_i = ~st;
            add_start_i = ~ast; add_off_i = ~aoff; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        seen = 0;
        for (int c = 0; c < 300 && !seen; c++) begin
            if (done_o) begin
                seen = 1;
                exp_tag = nt; exp_state = ns;
                check(busy_o == 1'b0, "R9 busy falls with done", busy_o, 0);
                check(tag_o == exp_tag, rq, tag_o, exp_tag);
                check(state_o == exp_state, rq, state_o, exp_state);
            end else begin
                cmp_hold("R10 outputs hold while busy");
                @(negedge clk);
            end
        end
        if (!seen) check(0, "R9 no done within bound", 0, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done is one cycle", done_o, 0);
        cmp_hold("R10 outputs hold after done");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(tag_o == 0 && state_o == 0, "R11 reset outputs", {tag_o, state_o}, 0);
        check(busy_o == 0 && done_o == 0, "R11 reset flags", {busy_o, done_o}, 0);

        // R3 R6: plain random request, no exclusions
        run_req("R3 R6 random no mask", 0, 16'h0000, 17'h00000, 24'hACE105, 0, 0, 0);
        // R1: op mask and control mask both contribute
        run_req("R1 combined mask", 0, 16'h00F0, 17'h0F000, 24'h1234_07, 0, 0, 0);
        // R2: all excluded through the OR of both masks
        run_req("R2 all excluded", 0, 16'hFF00, 17'h000FF, 24'hBEEF09, 0, 0, 0);
        // R7: zero seed with random bit uses the fallback seed
        run_req("R7 zero seed fallback", 0, 16'h0000, 17'h10000, 24'h000003, 0, 0, 0);
        // R7 R4: zero seed without random bit stays zero, offset zero
        run_req("R7 R4 zero seed kept", 0, 16'h0000, 17'h00038, 24'h000003, 0, 0, 0);
        // R8 R4: add mode, zero hop, start excluded, op mask ignored
        run_req("R8 R4 add zero hop", 1, 16'hFFFF, 17'h00600, 24'h000000, 4'd9, 4'd0, 0);
        // R8 R5: add mode hop 3 with wrap past 15
        run_req("R8 R5 add wrap", 1, 16'hFFFF, 17'h0C003, 24'h000000, 4'd13, 4'd3, 0);
        // R5: maximum hop with a sparse allowed set
        run_req("R5 add max hop", 1, 16'h0000, 17'h0EEEE, 24'h000000, 4'd2, 4'd15, 0);
        // R10: request while busy is ignored
        run_req("R10 busy request ignored", 0, 16'h7FFE, 17'h00000, 24'h5A5A0C, 0, 0, 1);
        // R3 R6: chained requests feeding state back
        for (int i = 0; i < 24; i++) begin
            st = state_o;
            run_req("R3 R6 chained random", 0, 16'(i * 16'h1357) & 16'h5AF0,
                    {1'b1, 16'(16'h0101 << (i % 8))}, st, 0, 0, 0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule